// File: doc/BRIEF.md
# Audio Capture Ring Writer

The block records four processed audio streams into fixed circular windows of a 16-bit-word audio memory. The four streams are the left and right disc-audio samples after volume scaling and two voice channels after envelope shaping. Every sample is a signed 16-bit value, and the streams arrive together at the output sample rate (44.1 kHz). On each sample strobe the block latches all four samples. It then performs four single-word writes through a request/grant memory port and, after the fourth grant, advances one position counter that all four windows share.

Each window is 1 KB of memory, which is 512 words, and wraps back to its start. Because memory is addressed in 16-bit words, a window's word index is its byte address divided by two. A host reads the current ring position and a half-fill toggle to find which half of every window was filled most recently, and so which half it can copy safely. DRAM timing, refresh and host transfers are handled elsewhere.

Top module: `capture_ring_writer`

## Requirements
- R1: While and after reset, `mem_req`, `busy` and `overrun` are 0, and `ring_pos` and `half_toggle` are 0.
- R2: A `sample_tick` taken while idle produces exactly four writes, in the order disc-left, disc-right, voice A, voice B. The written data is the sample presented on the tick cycle.
- R3: The word address of each write is region*512 + `ring_pos`. The region number 0..3 (disc-left, disc-right, voice A, voice B) sits in `mem_addr[10:9]`, the position sits in `mem_addr[8:0]`, and `mem_addr[17:11]` is zero. This gives word windows at 0x000, 0x200, 0x400 and 0x600.
- R4: While `mem_req` is high and `mem_gnt` is low, `mem_req`, `mem_addr` and `mem_wdata` hold their values.
- R5: `ring_pos` rises by exactly one in the cycle after the fourth write is granted, and goes from 511 back to 0.
- R6: `half_toggle` flips when `ring_pos` goes from 255 to 256 and again when it goes from 511 to 0. It does not change at any other time.
- R7: A `sample_tick` that arrives while writes are pending sets `overrun`. `overrun` stays set until reset. The late tick starts no writes and does not change the pending data.
- R8: Changes on the sample inputs after the tick cycle have no effect on the data written.
- R9: `busy` is high from the cycle after an accepted tick until the cycle after the final grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | One-cycle strobe at the output sample rate |
| cd_left | input | 16 | Disc-audio left sample after volume scaling |
| cd_right | input | 16 | Disc-audio right sample after volume scaling |
| voice_a | input | 16 | First captured voice sample after envelope shaping |
| voice_b | input | 16 | Second captured voice sample after envelope shaping |
| mem_req | output | 1 | Write request to audio memory |
| mem_gnt | input | 1 | Grant; a write completes on a clock edge where both `mem_req` and `mem_gnt` are high |
| mem_addr | output | 18 | Word index of the write |
| mem_wdata | output | 16 | Word to write |
| ring_pos | output | 9 | Current shared ring position |
| half_toggle | output | 1 | Flips each time a half of every window completes |
| busy | output | 1 | Writes for the current tick are pending |
| overrun | output | 1 | Sticky flag: a tick arrived while the block was busy |

## Verification
Grants are withheld in an irregular pattern, so each request must hold while it waits. A design that let the address or data move while waiting, or that skipped a stream, would put the wrong word in the scoreboard. The sample inputs change right after each tick; a design that read them live at grant time instead of latching them would write the new values. A second tick is sent while writes are stalled. A design that restarted the sequence would issue extra writes, and one that did not keep the flag would lose `overrun`. The bench runs more than a full ring of ticks to check the toggle at 255→256 and at 511→0 and the wrap of the address back to each window's start. An off-by-one in the half detect, or a position counter that did not wrap, would be reported there.

// File: rtl/cap_ring_pkg.sv
package cap_ring_pkg;

  // Stream order is also the write order and the region number.
  typedef enum logic [1:0] {
    STRM_CD_L  = 2'd0,
    STRM_CD_R  = 2'd1,
    STRM_VOX_A = 2'd2,
    STRM_VOX_B = 2'd3
  } stream_e;

  localparam int unsigned NUM_STREAMS = 4;
  localparam int unsigned STREAM_IDX_W = 2;

endpackage

// File: rtl/cap_ring_seq.sv
module cap_ring_seq #(
  parameter int unsigned N_SLOTS = 4,
  parameter int unsigned SLOT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              gnt,
  output logic              busy,
  output logic              req,
  output logic              accept,
  output logic              step,
  output logic              finish,
  output logic [SLOT_W-1:0] next_slot,
  output logic              overrun
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOTS - 1);

  logic [SLOT_W-1:0] slot_q;
  logic              fire;

  always_comb begin
    accept    = tick && !busy;
    fire      = req && gnt;
    finish    = fire && (slot_q == LAST_SLOT);
    step      = fire && (slot_q != LAST_SLOT);
    next_slot = slot_q + SLOT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      req     <= 1'b0;
      slot_q  <= '0;
      overrun <= 1'b0;
    end else begin
      if (accept) begin
        busy   <= 1'b1;
        req    <= 1'b1;
        slot_q <= '0;
      end else if (finish) begin
        busy   <= 1'b0;
        req    <= 1'b0;
        slot_q <= '0;
      end else if (step) begin
        slot_q <= next_slot;
      end
      if (tick && busy) begin
        overrun <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cap_ring_pos.sv
module cap_ring_pos #(
  parameter int unsigned POS_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [POS_W-1:0] pos,
  output logic             half_toggle
);

  logic half_end;

  // The last index of either half: all bits below the MSB are ones.
  always_comb half_end = &pos[POS_W-2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pos         <= '0;
      half_toggle <= 1'b0;
    end else if (adv) begin
      pos <= pos + POS_W'(1);
      if (half_end) begin
        half_toggle <= ~half_toggle;
      end
    end
  end

endmodule

// File: rtl/cap_ring_dp.sv
module cap_ring_dp #(
  parameter int unsigned SAMPLE_W  = 16,
  parameter int unsigned N_SLOTS   = 4,
  parameter int unsigned SLOT_W    = 2,
  parameter int unsigned POS_W     = 9,
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned BASE_WORD = 0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load_first,
  input  logic                        load_next,
  input  logic [SLOT_W-1:0]           next_slot,
  input  logic [POS_W-1:0]            pos,
  input  logic [N_SLOTS*SAMPLE_W-1:0] samples_flat,
  output logic [ADDR_W-1:0]           addr,
  output logic [SAMPLE_W-1:0]         wdata
);

  logic [SAMPLE_W-1:0] in_smp   [N_SLOTS];
  logic [SAMPLE_W-1:0] hold     [N_SLOTS];
  logic [ADDR_W-1:0]   base_tab [N_SLOTS];

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    assign in_smp[g]   = samples_flat[g*SAMPLE_W +: SAMPLE_W];
    assign base_tab[g] = ADDR_W'(BASE_WORD) + (ADDR_W'(g) << POS_W);

    always_ff @(posedge clk) begin
      if (load_first) begin
        hold[g] <= in_smp[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      wdata <= '0;
    end else if (load_first) begin
      addr  <= base_tab[0] + ADDR_W'(pos);
      wdata <= in_smp[0];
    end else if (load_next) begin
      addr  <= base_tab[next_slot] + ADDR_W'(pos);
      wdata <= hold[next_slot];
    end
  end

endmodule

// File: rtl/capture_ring_writer.sv
module capture_ring_writer
  import cap_ring_pkg::*;
#(
  parameter int unsigned SAMPLE_W  = 16,
  parameter int unsigned POS_W     = 9,
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned BASE_WORD = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sample_tick,
  input  logic [SAMPLE_W-1:0] cd_left,
  input  logic [SAMPLE_W-1:0] cd_right,
  input  logic [SAMPLE_W-1:0] voice_a,
  input  logic [SAMPLE_W-1:0] voice_b,
  output logic                mem_req,
  input  logic                mem_gnt,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [SAMPLE_W-1:0] mem_wdata,
  output logic [POS_W-1:0]    ring_pos,
  output logic                half_toggle,
  output logic                busy,
  output logic                overrun
);

  localparam int unsigned NS = NUM_STREAMS;
  localparam int unsigned SW = STREAM_IDX_W;

  logic                   accept;
  logic                   step;
  logic                   finish;
  logic [SW-1:0]          next_slot;
  logic [NS*SAMPLE_W-1:0] samples_flat;

  assign samples_flat = {voice_b, voice_a, cd_right, cd_left};

  cap_ring_seq #(.N_SLOTS(NS), .SLOT_W(SW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (sample_tick),
    .gnt       (mem_gnt),
    .busy      (busy),
    .req       (mem_req),
    .accept    (accept),
    .step      (step),
    .finish    (finish),
    .next_slot (next_slot),
    .overrun   (overrun)
  );

  cap_ring_pos #(.POS_W(POS_W)) u_pos (
    .clk         (clk),
    .rst         (rst),
    .adv         (finish),
    .pos         (ring_pos),
    .half_toggle (half_toggle)
  );

  cap_ring_dp #(
    .SAMPLE_W  (SAMPLE_W),
    .N_SLOTS   (NS),
    .SLOT_W    (SW),
    .POS_W     (POS_W),
    .ADDR_W    (ADDR_W),
    .BASE_WORD (BASE_WORD)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .load_first   (accept),
    .load_next    (step),
    .next_slot    (next_slot),
    .pos          (ring_pos),
    .samples_flat (samples_flat),
    .addr         (mem_addr),
    .wdata        (mem_wdata)
  );

endmodule

// File: rtl/capture_ring_writer_chk.sv
module capture_ring_writer_chk #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned POS_W    = 9,
  parameter int unsigned ADDR_W   = 18
) (
  input logic                clk,
  input logic                rst,
  input logic                sample_tick,
  input logic                mem_req,
  input logic                mem_gnt,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [SAMPLE_W-1:0] mem_wdata,
  input logic [POS_W-1:0]    ring_pos,
  input logic                half_toggle,
  input logic                busy,
  input logic                overrun
);

  logic [1:0] region;
  assign region = mem_addr[POS_W+1:POS_W];

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!mem_req && !busy && !overrun && ring_pos == '0 && !half_toggle));

  // R2
  slot_order_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_gnt && region != 2'd3) |=> (mem_req && region == $past(region) + 2'd1));

  // R3
  addr_pos_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[POS_W-1:0] == ring_pos && mem_addr[ADDR_W-1:POS_W+2] == '0));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

  // R5
  pos_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_gnt && region == 2'd3) |=> (ring_pos == POS_W'($past(ring_pos) + 1'b1)));

  // R6
  toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (half_toggle != $past(half_toggle)) |-> ($past(ring_pos[POS_W-2:0]) == '1 && ring_pos != $past(ring_pos)));

  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  // R9
  busy_req_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

endmodule

bind capture_ring_writer capture_ring_writer_chk #(
  .SAMPLE_W (SAMPLE_W),
  .POS_W    (POS_W),
  .ADDR_W   (ADDR_W)
) u_chk (.*);

// File: tb/sim_capture_ring_writer.sv
`timescale 1ns/1ps
module sim_capture_ring_writer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sample_tick = 1'b0;
  logic [15:0] cd_left = '0, cd_right = '0, voice_a = '0, voice_b = '0;
  logic        mem_req;
  logic        mem_gnt = 1'b0;
  logic [17:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [8:0]  ring_pos;
  logic        half_toggle, busy, overrun;

  int          n_chk = 0;
  int          n_fail = 0;
  bit          gnt_en = 1'b0;
  logic [7:0]  lfsr = 8'hA5;
  logic [8:0]  exp_pos = '0;
  logic [33:0] sb[$];

  always #2.5 clk = ~clk;

  capture_ring_writer u0 (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Monitor: picks the grant for the coming edge and scores the write it completes.
  always @(negedge clk) begin
    logic g;
    logic [33:0] e;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    g = gnt_en && (lfsr[0] || lfsr[3]);
    if (mem_req && g) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R2 unexpected write", {mem_addr, mem_wdata}, 0);
      end else begin
        e = sb.pop_front();
        chk(mem_addr == e[33:16], "R3 write address", mem_addr, e[33:16]);
        chk(mem_wdata == e[15:0], "R2 write data", mem_wdata, e[15:0]);
      end
    end
    mem_gnt = g;
  end

  // Driver: presents a tick, queues the four expected writes, then scrambles inputs (R8).
  task automatic tick_issue(input logic [15:0] a, b, c, d);
    @(negedge clk);
    sample_tick = 1'b1;
    cd_left = a; cd_right = b; voice_a = c; voice_b = d;
    sb.push_back({18'(0 * 512 + exp_pos), a});
    sb.push_back({18'(1 * 512 + exp_pos), b});
    sb.push_back({18'(2 * 512 + exp_pos), c});
    sb.push_back({18'(3 * 512 + exp_pos), d});
    @(negedge clk);
    sample_tick = 1'b0;
    cd_left = ~a; cd_right = ~b; voice_a = ~c; voice_b = ~d;
  endtask

  task automatic tick_finish();
    while (busy) @(negedge clk);
    exp_pos = exp_pos + 9'd1;
    chk(ring_pos == exp_pos, "R5 position step", ring_pos, exp_pos);
  endtask

  task automatic send(input logic [15:0] a, b, c, d);
    tick_issue(a, b, c, d);
    tick_finish();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    logic [17:0] a0;
    logic [15:0] d0;
    bit          no_req;
    repeat (4) @(negedge clk);
    // R1 state during reset
    chk(!mem_req && !busy && !overrun, "R1 reset controls", {mem_req, busy, overrun}, 0);
    chk(ring_pos == 0 && !half_toggle, "R1 reset position", {half_toggle, ring_pos}, 0);
    rst = 1'b0;
    gnt_en = 1'b1;

    send(16'h8000, 16'h7FFF, 16'h0000, 16'hFFFF);
    send(16'h1234, 16'hABCD, 16'h5555, 16'hAAAA);
    send(16'h0001, 16'hFFFE, 16'h8001, 16'h7FFE);

    // R9 and R4: stall the grants and watch the held request
    gnt_en = 1'b0;
    tick_issue(16'h1111, 16'h2222, 16'h3333, 16'h4444);
    chk(busy == 1'b1, "R9 busy after tick", busy, 1);
    a0 = mem_addr; d0 = mem_wdata;
    // R7: a second tick while busy
    sample_tick = 1'b1;
    cd_left = 16'hDEAD; cd_right = 16'hBEEF; voice_a = 16'hCAFE; voice_b = 16'hF00D;
    @(negedge clk);
    sample_tick = 1'b0;
    repeat (2) @(negedge clk);
    chk(overrun == 1'b1, "R7 overrun set", overrun, 1);
    chk(mem_req && mem_addr == a0 && mem_wdata == d0, "R4 request held", {mem_addr, mem_wdata}, {a0, d0});
    gnt_en = 1'b1;
    tick_finish();
    chk(sb.size() == 0, "R7 no extra writes queued", sb.size(), 0);
    no_req = 1'b1;
    repeat (12) begin
      @(negedge clk);
      if (mem_req || busy) no_req = 1'b0;
    end
    chk(no_req, "R7 late tick started nothing", !no_req, 0);
    chk(ring_pos == exp_pos, "R7 position unchanged by late tick", ring_pos, exp_pos);

    // Run up to the half boundary
    for (int k = 0; exp_pos != 9'd255; k++) begin
      send(16'(k * 3 + 1), 16'(k * 5 + 2), 16'(k * 7 + 3), 16'(~k));
    end
    chk(half_toggle == 1'b0, "R6 toggle before half", half_toggle, 0);
    send(16'h0F0F, 16'hF0F0, 16'h00FF, 16'hFF00);
    chk(half_toggle == 1'b1, "R6 toggle at 256", half_toggle, 1);
    for (int k = 0; exp_pos != 9'd511; k++) begin
      send(16'(k * 11), 16'(k * 13 + 7), 16'(k ^ 16'h5A5A), 16'(k + 16'h4000));
    end
    chk(half_toggle == 1'b1, "R6 toggle before wrap", half_toggle, 1);
    send(16'h7777, 16'h8888, 16'h9999, 16'hAAAA);
    chk(ring_pos == 9'd0, "R5 wrap to zero", ring_pos, 0);
    chk(half_toggle == 1'b0, "R6 toggle at wrap", half_toggle, 0);
    send(16'h0102, 16'h0304, 16'h0506, 16'h0708);
    chk(overrun == 1'b1, "R7 overrun sticky", overrun, 1);
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R2 all writes seen", sb.size(), 0);
    report();
  end

endmodule